// File: doc/BRIEF.md
# Single-Wire Bus Identity Search Master

This block is the master-side engine that discovers the 64-bit identities of every slave hanging on a wired-AND single-wire bus. It does not time the bus itself; it drives a bit-level bus agent through a one-operation-at-a-time handshake. It asks for a bus reset with presence detection, a single written bit, or a single read bit, and waits for the agent to report completion.

Each `start` request runs one full search pass. The pass resets the bus, sends the search code, and then walks all identity bit positions from the least significant upward. At each position it reads the bit, reads its complement, decides a direction and writes it back, so that only the slaves that match stay selected. The branch-point bookkeeping is kept between passes. Repeated passes therefore return every slave once, and the pass that finds the last slave raises a flag. Either the normal search or the active-only search, in which only slaves with their output switched on take part, can be requested for each pass.

Top module: `idsearch_master`

## Requirements
- R1: After `start`, the first bus operation is a reset (`bus_op`=0), followed by 8 write operations (`bus_op`=1) carrying the search code least significant bit first: F0h when `active_only` was 0 at start, ECh when it was 1. Read operations use `bus_op`=2.
- R2: For each of the 64 positions, starting at bit 0, the master issues read, read, write. The bit written at position i becomes bit i of `rom_id`.
- R3: A read pair of (bit=0, complement=1) forces direction 0, and a pair of (1, 0) forces direction 1, regardless of the search history.
- R4: On a conflict pair (0, 0), the direction is 0 above the previous last-discrepancy position, 1 at that position, and the previous pass's bit below it. Successive passes therefore return identities in ascending order of their bit-reversed value.
- R5: `last_dev` is 1 on a pass whose conflicts all took direction 1, and 0 on the others. The `start` that follows such a pass begins the enumeration again from the first identity.
- R6: If the reset reports no presence (`bus_rbit`=0 on the reset completion), the pass ends with `no_dev`=1, `last_dev`=0, and no further bus operation.
- R7: A read pair of (1, 1) ends the pass at once with `no_dev`=1.
- R8: `done` is a one-cycle pulse. `rom_id`, `last_dev` and `no_dev` change only with `done`, and `rom_id` keeps its old value on a `no_dev` pass. All outputs are 0 after reset.
- R9: In active-only mode, only the slaves with their output switched on are enumerated, in the same order as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one search pass (taken while idle) |
| active_only | input | 1 | Use the active-only search code for this pass |
| bus_go | output | 1 | One-cycle request to the bit-level bus agent |
| bus_op | output | 2 | Operation: 0 reset, 1 write bit, 2 read bit |
| bus_wbit | output | 1 | Bit to write for a write operation |
| bus_done | input | 1 | Agent completion pulse |
| bus_rbit | input | 1 | Read result, or presence (1 = present) for a reset |
| done | output | 1 | Pass finished |
| rom_id | output | 64 | Identity found by the last successful pass |
| last_dev | output | 1 | That pass found the final slave |
| no_dev | output | 1 | Pass ended without any responding slave |

## Verification
The bench puts a behavioural wired-AND slave population behind the bus agent. It predicts the enumeration order by sorting the participating identities on their bit-reversed value. A master that mishandled the last-discrepancy rule would repeat an identity or skip one. The test sets include identities that differ only in their top bits, so the conflicts come late in the pass, and identities that differ only in their low byte, so they come early; wrong ordering of the forced-versus-inherited choice shows up as a misordered list. The empty bus, a population with no active slave under active-only search, and a single slave probe the R6, R7 and R3 exits. The operation counts the slave model records show whether the master stopped issuing operations on those exits. The bench also checks that a found identity survives a failed pass and that the search wraps back to the first slave after the last.

// File: rtl/srch_pkg.sv
package srch_pkg;
  typedef enum logic [1:0] {
    BUS_RESET = 2'd0,
    BUS_WRITE = 2'd1,
    BUS_READ  = 2'd2
  } bus_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST,
    ST_CMD,
    ST_RDA,
    ST_RDB,
    ST_WR
  } st_e;
endpackage

// File: rtl/srch_idreg.sv
module srch_idreg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         din,
  output logic [W-1:0] q
);
  // New bits enter at the top; after W shifts bit i holds the bit of position i.
  // Before shifting, q[0] is last pass's bit for the current position.
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (shift) q <= {din, q[W-1:1]};
  end
endmodule

// File: rtl/srch_decide.sv
module srch_decide #(
  parameter int PW = 7
) (
  input  logic          a,
  input  logic          b,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] last_disc,
  input  logic          prev,
  output logic          dir,
  output logic          zero_conf,
  output logic          none
);
  always_comb begin
    none = a & b;
    if (a != b)               dir = a;
    else if (pos < last_disc) dir = prev;
    else if (pos == last_disc) dir = 1'b1;
    else                      dir = 1'b0;
    zero_conf = ~a & ~b & ~dir;
  end
endmodule

// File: rtl/idsearch_master.sv
module idsearch_master #(
  parameter int          ID_W     = 64,
  parameter logic [7:0]  CODE_ALL = 8'hF0,
  parameter logic [7:0]  CODE_ACT = 8'hEC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            active_only,
  output logic            bus_go,
  output logic [1:0]      bus_op,
  output logic            bus_wbit,
  input  logic            bus_done,
  input  logic            bus_rbit,
  output logic            done,
  output logic [ID_W-1:0] rom_id,
  output logic            last_dev,
  output logic            no_dev
);
  import srch_pkg::*;

  localparam int PW = $clog2(ID_W + 1);
  localparam int CW = 8;
  localparam int CBW = $clog2(CW);
  localparam logic [PW-1:0] POS_LAST = PW'(ID_W);
  localparam logic [CBW-1:0] CBIT_LAST = CBW'(CW - 1);

  st_e            st;
  logic           pend;
  logic [CBW-1:0] cbit;
  logic [CW-1:0]  code;
  logic [PW-1:0]  pos, last_disc, last_zero;
  logic           bit_a, dir_r;
  logic [ID_W-1:0] sr_q;
  logic           sr_shift;
  logic           dec_dir, dec_zero, dec_none;

  srch_idreg #(.W(ID_W)) u_idreg (
    .clk   (clk),
    .rst   (rst),
    .shift (sr_shift),
    .din   (dir_r),
    .q     (sr_q)
  );

  srch_decide #(.PW(PW)) u_decide (
    .a         (bit_a),
    .b         (bus_rbit),
    .pos       (pos),
    .last_disc (last_disc),
    .prev      (sr_q[0]),
    .dir       (dec_dir),
    .zero_conf (dec_zero),
    .none      (dec_none)
  );

  assign sr_shift = pend && bus_done && (st == ST_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      pend      <= 1'b0;
      cbit      <= '0;
      code      <= '0;
      pos       <= '0;
      last_disc <= '0;
      last_zero <= '0;
      bit_a     <= 1'b0;
      dir_r     <= 1'b0;
      bus_go    <= 1'b0;
      bus_op    <= BUS_RESET;
      bus_wbit  <= 1'b0;
      done      <= 1'b0;
      rom_id    <= '0;
      last_dev  <= 1'b0;
      no_dev    <= 1'b0;
    end else begin
      bus_go <= 1'b0;
      done   <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          code      <= active_only ? CODE_ACT : CODE_ALL;
          cbit      <= '0;
          pos       <= PW'(1);
          last_zero <= '0;
          if (last_dev) last_disc <= '0;
          st        <= ST_RST;
        end
      end else if (!pend) begin
        bus_go <= 1'b1;
        pend   <= 1'b1;
        unique case (st)
          ST_RST:  begin bus_op <= BUS_RESET; bus_wbit <= 1'b0;       end
          ST_CMD:  begin bus_op <= BUS_WRITE; bus_wbit <= code[cbit]; end
          ST_WR:   begin bus_op <= BUS_WRITE; bus_wbit <= dir_r;      end
          default: begin bus_op <= BUS_READ;  bus_wbit <= 1'b0;       end
        endcase
      end else if (bus_done) begin
        pend <= 1'b0;
        unique case (st)
          ST_RST: begin
            if (!bus_rbit) begin
              done <= 1'b1; no_dev <= 1'b1; last_dev <= 1'b0;
              last_disc <= '0; st <= ST_IDLE;
            end else st <= ST_CMD;
          end
          ST_CMD: begin
            cbit <= cbit + 1'b1;
            if (cbit == CBIT_LAST) st <= ST_RDA;
          end
          ST_RDA: begin
            bit_a <= bus_rbit;
            st    <= ST_RDB;
          end
          ST_RDB: begin
            if (dec_none) begin
              done <= 1'b1; no_dev <= 1'b1; last_dev <= 1'b0;
              last_disc <= '0; st <= ST_IDLE;
            end else begin
              dir_r <= dec_dir;
              if (dec_zero) last_zero <= pos;
              st <= ST_WR;
            end
          end
          ST_WR: begin
            if (pos == POS_LAST) begin
              done      <= 1'b1;
              no_dev    <= 1'b0;
              rom_id    <= {dir_r, sr_q[ID_W-1:1]};
              last_disc <= last_zero;
              last_dev  <= (last_zero == '0);
              st        <= ST_IDLE;
            end else begin
              pos <= pos + 1'b1;
              st  <= ST_RDA;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  // Assertions
  assert_go_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    bus_go |=> !bus_go);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !(last_dev && no_dev));
  assert_rom_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (done && no_dev) |-> rom_id == $past(rom_id));
  assert_last_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(last_dev) |-> done);
  assert_pos_range_R2: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |-> (pos >= PW'(1) && pos <= POS_LAST));
endmodule

// File: tb/idsearch_master_test.sv
module idsearch_master_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic active_only = 1'b0;
  logic bus_go;
  logic [1:0] bus_op;
  logic bus_wbit;
  logic bus_done = 1'b0;
  logic bus_rbit = 1'b0;
  logic done;
  logic [63:0] rom_id;
  logic last_dev, no_dev;

  always #4 clk = ~clk;

  idsearch_master uut (
    .clk(clk), .rst(rst), .start(start), .active_only(active_only),
    .bus_go(bus_go), .bus_op(bus_op), .bus_wbit(bus_wbit),
    .bus_done(bus_done), .bus_rbit(bus_rbit), .done(done),
    .rom_id(rom_id), .last_dev(last_dev), .no_dev(no_dev)
  );

  int tests = 0;
  int fails = 0;

  // Slave population model
  logic [63:0] ids[8];
  bit act[8];
  bit sel[8];
  int nsl = 0;
  int dly = 0;
  logic [1:0] lop = 2'd0;
  logic lwbit = 1'b0;
  logic [7:0] cmdseen = 8'h00;
  int cmdn = 0, bitpos = 0, rdcnt = 0, ops_after = 0, reads_after = 0;

  always @(posedge clk) begin
    bus_done <= 1'b0;
    if (dly == 1) begin
      dly = 0;
      bus_done <= 1'b1;
      if (lop == 2'd0) begin
        bus_rbit <= (nsl > 0);
        for (int s = 0; s < 8; s++) sel[s] = (s < nsl);
        cmdn = 0; cmdseen = 8'h00; bitpos = 0; rdcnt = 0;
        ops_after = 0; reads_after = 0;
      end else if (lop == 2'd1) begin
        ops_after++;
        if (cmdn < 8) begin
          cmdseen[cmdn] = lwbit;
          cmdn++;
          if (cmdn == 8)
            for (int s = 0; s < 8; s++)
              sel[s] = sel[s] && ((cmdseen == 8'hF0) || (cmdseen == 8'hEC && act[s]));
        end else begin
          for (int s = 0; s < 8; s++)
            if (bitpos < 64 && ids[s][bitpos] != lwbit) sel[s] = 1'b0;
          bitpos++;
          rdcnt = 0;
        end
      end else begin
        logic v;
        ops_after++;
        reads_after++;
        v = 1'b1;
        if (cmdn == 8 && bitpos < 64)
          for (int s = 0; s < 8; s++)
            if (sel[s]) v = v & ((rdcnt == 0) ? ids[s][bitpos] : ~ids[s][bitpos]);
        rdcnt = rdcnt ^ 1;
        bus_rbit <= v;
      end
    end else if (dly > 1) dly = dly - 1;
    if (bus_go) begin
      lop = bus_op; lwbit = bus_wbit; dly = 2;
    end
  end

  function automatic logic [63:0] rev64(input logic [63:0] x);
    return {<<{x}};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] a, input logic [63:0] e);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, a, e);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pass(input bit am);
    int wd;
    @(negedge clk);
    start = 1'b1; active_only = am;
    @(negedge clk);
    start = 1'b0;
    wd = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R8 actual=%0d expected=done", wd);
    end
  endtask

  task automatic run_set(input string tag, input bit am);
    logic [63:0] ex[8];
    logic [63:0] t;
    int m;
    m = 0;
    for (int s = 0; s < nsl; s++) if (!am || act[s]) begin ex[m] = ids[s]; m++; end
    for (int i = 0; i < m; i++)
      for (int j = 0; j + 1 < m - i; j++)
        if (rev64(ex[j]) > rev64(ex[j+1])) begin t = ex[j]; ex[j] = ex[j+1]; ex[j+1] = t; end
    for (int k = 0; k < m; k++) begin
      pass(am);
      chk(cmdseen == (am ? 8'hEC : 8'hF0), {tag, " R1 search code"}, cmdseen, am ? 8'hEC : 8'hF0);
      chk(rom_id == ex[k], {tag, am ? " R9/R4 identity" : " R2/R4 identity"}, rom_id, ex[k]);
      chk(last_dev == (k == m - 1), {tag, " R5 last flag"}, last_dev, (k == m - 1));
      chk(no_dev == 1'b0, {tag, " R6 no_dev clear"}, no_dev, 0);
      @(negedge clk);
      chk(done == 1'b0, {tag, " R8 done pulse"}, done, 0);
    end
    if (m > 0) begin
      pass(am);
      chk(rom_id == ex[0], {tag, " R5 restart"}, rom_id, ex[0]);
    end
  endtask

  initial begin
    logic [63:0] held;
    for (int s = 0; s < 8; s++) begin ids[s] = '0; act[s] = 1'b0; sel[s] = 1'b0; end
    do_reset();
    chk(done == 0 && no_dev == 0 && last_dev == 0, "R8 reset flags", {done, no_dev, last_dev}, 0);
    chk(rom_id == 0, "R8 reset id", rom_id, 0);
    chk(bus_go == 0, "R8 reset bus_go", bus_go, 0);

    // R6: empty bus
    nsl = 0;
    pass(1'b0);
    chk(no_dev == 1'b1, "R6 no presence", no_dev, 1);
    chk(last_dev == 1'b0, "R6 last_dev", last_dev, 0);
    chk(ops_after == 0, "R6 no ops after reset", ops_after, 0);

    // R3: single slave, only forced bits
    do_reset();
    nsl = 1; ids[0] = 64'h5A00_0000_1234_5605;
    run_set("single R3", 1'b0);

    // early conflicts in low byte
    do_reset();
    nsl = 4;
    ids[0] = {56'h11_2222_3333_4444, 8'hAC};
    ids[1] = {56'h11_2222_3333_4444, 8'h55};
    ids[2] = {56'h11_2222_3333_4444, 8'hAF};
    ids[3] = {56'h11_2222_3333_4444, 8'h88};
    run_set("lowbyte", 1'b0);

    // scattered identities
    do_reset();
    nsl = 5;
    for (int s = 0; s < 5; s++) begin
      ids[s] = 64'h9E37_79B9_7F4A_7C15 * 64'(s * 3 + 1);
      act[s] = (s % 2) == 1;
    end
    run_set("scatter", 1'b0);

    // R9: active-only on the same population
    do_reset();
    run_set("active", 1'b1);
    held = rom_id;

    // R7: active-only with none active, no reset in between
    for (int s = 0; s < 8; s++) act[s] = 1'b0;
    pass(1'b1);
    chk(no_dev == 1'b1, "R7 empty pair", no_dev, 1);
    chk(reads_after == 2, "R7 stop after pair", reads_after, 2);
    chk(rom_id == held, "R8 id held on no_dev", rom_id, held);

    // late conflicts in top bits
    do_reset();
    nsl = 4;
    for (int s = 0; s < 4; s++) ids[s] = 64'h0123_4567_89AB_CDEF ^ (64'(s) << 61);
    run_set("topbits R4", 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    tests++; fails++;
    $display("FAIL global watchdog R8 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule